// File: doc/BRIEF.md
# Mask-to-Vector Expansion Unit

This execution slice converts a predicate mask, read from one of eight mask registers, into a 512-bit vector. Each element of the vector is filled with all ones or all zeros, depending on one mask bit. A decoded instruction descriptor supplies three things: an opcode byte and a W bit, which together pick the element size; a vector-length field, which sets how wide the result is; and a 4-bit reserved specifier field, which must hold all ones.

Elements inside the active width follow the mask, starting from bit 0 of the mask. All bits from the active width up to bit 511 are forced to zero. A descriptor that cannot be executed raises the illegal-instruction flag instead of writing. Results and flags appear one clock after the valid input. The unit touches no status flags and produces no floating-point exceptions.

Top module: `mask_expand_unit`

## Requirements
- R1: After a synchronous active-low reset, `resultWe` and `illegalOp` are 0 and `result` is all zeros.
- R2: The element size is decoded from the opcode and W bit as follows:
  - opcode 0x28 with W=0 selects 8-bit elements;
  - opcode 0x28 with W=1 selects 16-bit elements;
  - opcode 0x38 with W=0 selects 32-bit elements;
  - opcode 0x38 with W=1 selects 64-bit elements.
- R3: The `vecLen` field encodes the active width: 0 is 128 bits, 1 is 256 bits and 2 is 512 bits.
- R4: Element j of the result (bits j*E to j*E+E-1, where E is the element width) is all ones when mask bit j is 1 and all zeros when it is 0.
- R5: Every result bit from the active width up to bit 511 is 0.
- R6: Mask bits at index (active width / E) and above have no effect on the result.
- R7: When `rsvdSpec` is not 4'b1111, `illegalOp` is 1 one cycle later, `resultWe` stays 0 and `result` is unchanged.
- R8: A `vecLen` value of 3 raises `illegalOp` and performs no write.
- R9: An opcode other than 0x28 or 0x38 raises `illegalOp` and performs no write.
- R10: For a legal valid input, `resultWe` is 1 and `result` is updated on the next clock. The outputs `resultWe` and `illegalOp` are each high for exactly one cycle per valid input, and both are 0 one cycle after a cycle with no valid input. Back-to-back inputs are accepted every cycle.
- R11: The mask register read is `mrfData` at address `mrfAddr`, and `mrfAddr` equals `maskIdx` in the same cycle.
- R12: `result` keeps its value in every cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Descriptor valid this cycle |
| opcode | input | 8 | Opcode byte (0x28 or 0x38) |
| wBit | input | 1 | W bit of the descriptor |
| vecLen | input | 2 | Active width: 0=128, 1=256, 2=512 bits |
| rsvdSpec | input | 4 | Reserved specifier field, must be 4'b1111 |
| maskIdx | input | 3 | Source mask register index |
| mrfAddr | output | 3 | Mask register file read address |
| mrfData | input | 64 | Mask register file read data |
| result | output | 512 | Expanded vector result |
| resultWe | output | 1 | Result write strobe |
| illegalOp | output | 1 | Illegal-instruction flag |

## Verification
Every result of this unit falls due exactly one clock edge after the cycle in which its descriptor was presented. This applies to the written vector, the write strobe and the illegal flag. The bench drives each descriptor on a falling edge and reads all outputs on the following falling edge, which is half a period after the capturing rising edge. In the streaming test, the bench checks the previous descriptor's results on the same falling edge at which it drives the next descriptor. For faulting descriptors, the bench compares the held vector against the last legal result, which shows that no write took place.

// File: rtl/mxu_pkg.sv
package mxu_pkg;
  localparam int VEC_W    = 512;
  localparam int MASK_W   = 64;
  localparam int SEG_W    = 128;
  localparam int NUM_SEG  = VEC_W / SEG_W;
  localparam int MREG_CNT = 8;
  localparam int MIDX_W   = $clog2(MREG_CNT);
  localparam int NUM_ES   = 4;
  localparam int OPC_W    = 8;
  localparam int RSVD_W   = 4;
  localparam int VL_W     = 2;
  localparam logic [OPC_W-1:0]  OPC_NARROW = 8'h28;
  localparam logic [OPC_W-1:0]  OPC_WIDE   = 8'h38;
  localparam logic [RSVD_W-1:0] RSVD_OK    = 4'hF;

  typedef enum logic [1:0] {ES_BYTE, ES_WORD, ES_DWORD, ES_QWORD} elemSize_e;
  typedef enum logic [VL_W-1:0] {VL_128, VL_256, VL_512, VL_BAD} vecLen_e;

  typedef struct packed {
    logic                 doWrite;
    elemSize_e            elemSel;
    logic [NUM_SEG-1:0]   segKeep;
  } ctrlStrobe_t;
endpackage

// File: rtl/mxu_ctrl.sv
module mxu_ctrl
  import mxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              wBit,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [RSVD_W-1:0] rsvdSpec,
  output ctrlStrobe_t       strobe,
  output logic              resultWe,
  output logic              illegalOp
);
  logic isWide;
  logic opcKnown;
  logic lenOk;
  logic rsvdOk;
  logic isLegal;
  logic [NUM_SEG-1:0] segKeepV;

  assign isWide   = (opcode == OPC_WIDE);
  assign opcKnown = (opcode == OPC_NARROW) || isWide;
  assign lenOk    = (vecLen != VL_BAD);
  assign rsvdOk   = (rsvdSpec == RSVD_OK);
  assign isLegal  = opcKnown && lenOk && rsvdOk;

  // active segments = 1 << vecLen (128-bit units)
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign segKeepV[s] = (s < (1 << vecLen));
  end

  assign strobe.doWrite = inValid && isLegal;
  assign strobe.elemSel = elemSize_e'({isWide, wBit});
  assign strobe.segKeep = segKeepV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultWe  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      resultWe  <= inValid && isLegal;
      illegalOp <= inValid && !isLegal;
    end
  end

  // R7
  rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rsvdSpec != RSVD_OK) |=> (illegalOp && !resultWe));

  // R8
  bad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && vecLen == VL_BAD) |=> (illegalOp && !resultWe));

  // R9
  bad_opc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode != OPC_NARROW && opcode != OPC_WIDE) |=> illegalOp);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resultWe && !illegalOp));
endmodule

// File: rtl/mxu_datapath.sv
module mxu_datapath
  import mxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [MASK_W-1:0] maskWord,
  output logic [VEC_W-1:0]  result
);
  logic [NUM_ES-1:0][VEC_W-1:0] candidate;
  logic [VEC_W-1:0] selected;
  logic [VEC_W-1:0] lenMask;
  logic [VEC_W-1:0] nextResult;

  // one expansion per element size, lane count derived from width
  for (genvar es = 0; es < NUM_ES; es++) begin : g_size
    localparam int EB    = 8 << es;
    localparam int LANES = VEC_W / EB;
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign candidate[es][ln*EB +: EB] = {EB{maskWord[ln]}};
    end
  end

  assign selected = candidate[strobe.elemSel];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_len
    assign lenMask[s*SEG_W +: SEG_W] = {SEG_W{strobe.segKeep[s]}};
  end

  assign nextResult = selected & lenMask;

  always_ff @(posedge clk) begin
    if (!rstN)               result <= '0;
    else if (strobe.doWrite) result <= nextResult;
  end

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doWrite && !strobe.segKeep[NUM_SEG-1]) |=> (result[VEC_W-1 -: SEG_W] == '0));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doWrite |=> $stable(result));

  // R4
  lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doWrite |=> (result[0] == $past(maskWord[0])));
endmodule

// File: rtl/mask_expand_unit.sv
module mask_expand_unit
  import mxu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               wBit,
  input  logic [VL_W-1:0]    vecLen,
  input  logic [RSVD_W-1:0]  rsvdSpec,
  input  logic [MIDX_W-1:0]  maskIdx,
  output logic [MIDX_W-1:0]  mrfAddr,
  input  logic [MASK_W-1:0]  mrfData,
  output logic [VEC_W-1:0]   result,
  output logic               resultWe,
  output logic               illegalOp
);
  ctrlStrobe_t strobe;

  assign mrfAddr = maskIdx;

  mxu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .wBit     (wBit),
    .vecLen   (vecLen),
    .rsvdSpec (rsvdSpec),
    .strobe   (strobe),
    .resultWe (resultWe),
    .illegalOp(illegalOp)
  );

  mxu_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .maskWord(mrfData),
    .result  (result)
  );

  // R10
  we_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> $past(inValid));
endmodule

// File: tb/tb_mask_expand_unit.sv
`timescale 1ns/1ps
module tb_mask_expand_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [7:0]   opcode;
  logic         wBit;
  logic [1:0]   vecLen;
  logic [3:0]   rsvdSpec;
  logic [2:0]   maskIdx;
  logic [2:0]   mrfAddr;
  logic [63:0]  mrfData;
  logic [511:0] result;
  logic         resultWe;
  logic         illegalOp;

  logic [63:0]  mrf [8];
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign mrfData = mrf[mrfAddr];

  mask_expand_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .wBit(wBit),
    .vecLen(vecLen), .rsvdSpec(rsvdSpec), .maskIdx(maskIdx), .mrfAddr(mrfAddr),
    .mrfData(mrfData), .result(result), .resultWe(resultWe), .illegalOp(illegalOp)
  );

  function automatic logic [511:0] refExpand(input logic [7:0] op, input logic w,
                                             input logic [1:0] len, input logic [63:0] m);
    logic [511:0] r = '0;
    int eb = 8 << ((op == 8'h38 ? 2 : 0) + (w ? 1 : 0));
    int ab = 128 << len;
    for (int b = 0; b < 512; b++)
      if (b < ab) r[b] = m[b / eb];
    return r;
  endfunction

  task automatic chkVec(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] op, logic w, logic [1:0] len, logic [3:0] rs, logic [2:0] idx);
    inValid = 1'b1; opcode = op; wBit = w; vecLen = len; rsvdSpec = rs; maskIdx = idx;
  endtask

  // drive on a falling edge, outputs valid at the next falling edge
  task automatic issue(logic [7:0] op, logic w, logic [1:0] len, logic [3:0] rs, logic [2:0] idx);
    @(negedge clk);
    drive(op, w, len, rs, idx);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic t_reset();
    chkBit("R1 resultWe", resultWe, 1'b0);
    chkBit("R1 illegalOp", illegalOp, 1'b0);
    chkVec("R1 result", result, '0);
  endtask

  task automatic t_sweep();
    for (int sz = 0; sz < 4; sz++)
      for (int len = 0; len < 3; len++)
        for (int rep = 0; rep < 3; rep++) begin
          logic [2:0] idx = 3'((sz * 3 + len + rep) % 8);
          logic [7:0] op = (sz >= 2) ? 8'h38 : 8'h28;
          logic w = sz[0];
          mrf[idx] = {$urandom, $urandom};
          issue(op, w, 2'(len), 4'hF, idx);
          chkBit("R10 write strobe", resultWe, 1'b1);
          chkBit("R10 no fault", illegalOp, 1'b0);
          // R2 R3 R4 R5 R11
          chkVec("R2/R3/R4/R5/R11 sweep", result, refExpand(op, w, 2'(len), mrf[idx]));
        end
  endtask

  task automatic t_patterns();
    mrf[5] = '1;
    issue(8'h38, 1'b1, 2'd2, 4'hF, 3'd5);
    chkVec("R4 all ones qword", result, '1);
    mrf[6] = 64'h5555_5555_5555_5555;
    issue(8'h28, 1'b1, 2'd2, 4'hF, 3'd6);
    chkVec("R4 alternating words", result, {32{16'h0000, 16'hFFFF}});
    mrf[7] = '0;
    issue(8'h28, 1'b0, 2'd2, 4'hF, 3'd7);
    chkVec("R4 all zero bytes", result, '0);
    mrf[1] = 64'h0000_0000_0000_000F;
    issue(8'h38, 1'b0, 2'd0, 4'hF, 3'd1);
    chkVec("R5 dword 128", result, {384'b0, {128{1'b1}}});
  endtask

  task automatic t_ignore();
    mrf[2] = {48'hDEAD_BEEF_CAFE, 16'hA5C3};
    issue(8'h28, 1'b0, 2'd0, 4'hF, 3'd2);
    chkVec("R6 upper mask ignored byte/128", result, refExpand(8'h28, 1'b0, 2'd0, 64'h0000_0000_0000_A5C3));
    mrf[3] = 64'hFFFF_FFFF_FFFF_FF00;
    issue(8'h38, 1'b1, 2'd2, 4'hF, 3'd3);
    chkVec("R6 upper mask ignored qword/512", result, '0);
  endtask

  task automatic t_faults();
    logic [511:0] held;
    mrf[4] = 64'h0123_4567_89AB_CDEF;
    issue(8'h28, 1'b1, 2'd1, 4'hF, 3'd4);
    held = result;
    mrf[0] = '1;
    issue(8'h28, 1'b0, 2'd2, 4'hE, 3'd0);
    chkBit("R7 rsvd flag", illegalOp, 1'b1);
    chkBit("R7 rsvd no write", resultWe, 1'b0);
    chkVec("R7 rsvd result held", result, held);
    issue(8'h38, 1'b0, 2'd0, 4'h0, 3'd0);
    chkBit("R7 rsvd zero flag", illegalOp, 1'b1);
    issue(8'h28, 1'b0, 2'd3, 4'hF, 3'd0);
    chkBit("R8 bad len flag", illegalOp, 1'b1);
    chkBit("R8 bad len no write", resultWe, 1'b0);
    chkVec("R8 result held", result, held);
    issue(8'h29, 1'b0, 2'd2, 4'hF, 3'd0);
    chkBit("R9 bad opcode flag", illegalOp, 1'b1);
    chkBit("R9 bad opcode no write", resultWe, 1'b0);
    chkVec("R9 result held", result, held);
    @(negedge clk);
    chkBit("R10 idle no write", resultWe, 1'b0);
    chkBit("R10 idle no fault", illegalOp, 1'b0);
    chkVec("R12 held across idle", result, held);
  endtask

  task automatic t_stream();
    logic [511:0] exp;
    mrf[0] = 64'h0F0F_0F0F_0F0F_0F0F;
    mrf[1] = 64'h0000_0000_8000_0001;
    @(negedge clk);
    drive(8'h28, 1'b0, 2'd2, 4'hF, 3'd0);
    @(negedge clk);
    exp = refExpand(8'h28, 1'b0, 2'd2, mrf[0]);
    drive(8'h28, 1'b1, 2'd2, 4'hF, 3'd1);
    chkVec("R10 stream op0", result, exp);
    chkBit("R10 stream op0 we", resultWe, 1'b1);
    @(negedge clk);
    exp = refExpand(8'h28, 1'b1, 2'd2, mrf[1]);
    drive(8'h38, 1'b0, 2'd3, 4'hF, 3'd0);
    chkVec("R10 stream op1", result, exp);
    @(negedge clk);
    drive(8'h38, 1'b1, 2'd1, 4'hF, 3'd0);
    chkBit("R10 stream fault", illegalOp, 1'b1);
    chkBit("R10 stream fault no we", resultWe, 1'b0);
    chkVec("R12 stream held", result, exp);
    @(negedge clk);
    inValid = 1'b0;
    chkVec("R10 stream op3", result, refExpand(8'h38, 1'b1, 2'd1, mrf[0]));
    chkBit("R10 stream op3 we", resultWe, 1'b1);
    @(negedge clk);
    chkBit("R10 single pulse", resultWe, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mrf[i] = '0;
    inValid = 0; opcode = 0; wBit = 0; vecLen = 0; rsvdSpec = 4'hF; maskIdx = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_patterns();
    t_ignore();
    t_faults();
    t_stream();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule